// File: doc/BRIEF.md
# Two-Class Wormhole Mesh Router Tile

This block is one router tile of a two-dimensional mesh. It has five link ports (local, north, south, east, west). Each port carries two virtual channels over one shared physical link. Every input virtual channel has its own flit queue. The tile picks a route from the head flit's destination coordinates, locks an output virtual channel for the rest of the packet (wormhole switching), and forwards one flit per output port per cycle. Each output port has a round-robin arbiter that chooses among the input channels requesting it.

Class 0 is the primary class and routes X first, then Y. Class 1 is an escape class and routes Y first, then X. A class-0 head flit whose X-first output channel is already held by another packet moves to class 1 on the Y-first port. After that the packet stays on class 1 at every later hop. Flow control uses credits per virtual channel in both directions. The tile's coordinates are parameters.

Top module: `mesh_rtr`

## Requirements
- R1: While reset is low and in the first cycle after it, every `out_valid` and `in_crd` bit is 0. After reset, each output virtual channel holds DEPTH downstream credits.
- R2: A flit is FW bits wide. Bit FW-1 marks a head flit and bit FW-2 marks a tail flit; both set means a single-flit packet. The head's bits [CW-1:0] give the destination X and bits [2CW-1:CW] give the destination Y. Port index 0 is local, 1 north (Y+), 2 south (Y−), 3 east (X+) and 4 west (X−); the port and VC fields of the flattened buses are indexed port*2+vc. A class-0 packet leaves on class 0 through the X-first port: east or west while the X coordinates differ, and north or south after that.
- R3: A packet whose destination equals (X_POS, Y_POS) leaves on the local port.
- R4: If the class-0 output channel that a class-0 head needs is held, the head instead takes class 1 on the Y-first port. The class-1 packet then shares the physical link with the class-0 packet that holds the other channel.
- R5: A packet that arrives on class 1 leaves on class 1 through the Y-first port: north or south while the Y coordinates differ, and east or west after that.
- R6: Body and tail flits leave in order on the port and channel that their head took. After the tail passes, the output channel is released, and the next class-0 head that needs it gets it without being diverted.
- R7: No flit goes to an output channel that has zero credits. A held packet stops after DEPTH flits and resumes as credits return on `out_crd`.
- R8: Each flit that leaves an input queue returns exactly one credit pulse on `in_crd` for its port and channel. The pulse appears in the same cycle the flit appears at the output.
- R9: When two input channels continuously request the same output port, the grants alternate between them.
- R10: An uncontended head flit reaches the output registers two clock edges after it is presented at an input.

Input channel state machine: IV_IDLE →(head granted, not tail)→ IV_ACTIVE →(tail granted)→ IV_IDLE. A single-flit packet stays in IV_IDLE. Output channel state machine: OV_FREE →(head claim)→ OV_HELD →(tail sent)→ OV_FREE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 5 | A flit is present on the input link, one bit per port |
| in_vc | input | 5 | Virtual channel of the input flit, one bit per port |
| in_flit | input | 5*FW | Input flits, port p at [p*FW +: FW] |
| in_crd | output | 10 | Credit returned upstream, bit port*2+vc |
| out_valid | output | 5 | A flit is present on the output link |
| out_vc | output | 5 | Virtual channel of the output flit |
| out_flit | output | 5*FW | Output flits, port p at [p*FW +: FW] |
| out_crd | input | 10 | Credit returned from downstream, bit port*2+vc |

## Verification
The bench stops downstream credits on the east class-0 channel partway through a packet. It then checks that exactly DEPTH flits leave: a credit counter that miscounts lets flits overrun the buffer or stalls the channel early. While that channel stays held, new heads from the local port must come out on class 1 on the Y-first port. A tile without diversion leaves them stuck behind the stalled packet, and a tile that diverts onto the X-first port sends them east. After the tail passes, the next head must get class 0 again, which catches a release that never fires. Two packets competing for the east link must strictly interleave, and any deviation from the per-channel scoreboard order exposes a lock lost in mid-packet.

// File: rtl/mesh_rtr_pkg.sv
package mesh_rtr_pkg;
    localparam int NPORT = 5;
    localparam int NVC = 2;
    localparam int PSEL_W = 3;
    localparam int IDX_W = PSEL_W + 1;

    localparam logic [PSEL_W-1:0] P_LOC   = 3'd0;
    localparam logic [PSEL_W-1:0] P_NORTH = 3'd1;
    localparam logic [PSEL_W-1:0] P_SOUTH = 3'd2;
    localparam logic [PSEL_W-1:0] P_EAST  = 3'd3;
    localparam logic [PSEL_W-1:0] P_WEST  = 3'd4;

    typedef enum logic {IV_IDLE, IV_ACTIVE} iv_state_e;
    typedef enum logic {OV_FREE, OV_HELD} ov_state_e;

    function automatic logic [PSEL_W-1:0] route_xy(int dx, int dy, int mx, int my);
        if (dx > mx) return P_EAST;
        if (dx < mx) return P_WEST;
        if (dy > my) return P_NORTH;
        if (dy < my) return P_SOUTH;
        return P_LOC;
    endfunction

    function automatic logic [PSEL_W-1:0] route_yx(int dx, int dy, int mx, int my);
        if (dy > my) return P_NORTH;
        if (dy < my) return P_SOUTH;
        if (dx > mx) return P_EAST;
        if (dx < mx) return P_WEST;
        return P_LOC;
    endfunction
endpackage

// File: rtl/mesh_rtr_rr.sv
module mesh_rtr_rr #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [PTR_W-1:0] last_q;
    logic [PTR_W-1:0] win;
    logic             found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        win   = last_q;
        for (int i = 0; i < N; i++) begin
            if (!found && req[i] && (PTR_W'(i) > last_q)) begin
                grant[i] = 1'b1;
                found    = 1'b1;
                win      = PTR_W'(i);
            end
        end
        for (int i = 0; i < N; i++) begin
            if (!found && req[i]) begin
                grant[i] = 1'b1;
                found    = 1'b1;
                win      = PTR_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= PTR_W'(N - 1);
        end else if (found) begin
            last_q <= win;
        end
    end
endmodule

// File: rtl/mesh_rtr_ovc.sv
module mesh_rtr_ovc #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic send,
    input  logic claim,
    input  logic rel,
    input  logic crd_in,
    output logic held,
    output logic ok
);
    import mesh_rtr_pkg::*;
    localparam int CNT_W = $clog2(DEPTH + 1);

    ov_state_e        state_q, state_d;
    logic [CNT_W-1:0] crd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OV_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OV_FREE: if (claim) state_d = OV_HELD;
            OV_HELD: if (rel)   state_d = OV_FREE;
            default: state_d = OV_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crd_q <= CNT_W'(DEPTH);
        end else begin
            crd_q <= crd_q - CNT_W'(send) + CNT_W'(crd_in);
        end
    end

    always_comb begin
        held = (state_q == OV_HELD);
        ok   = (crd_q != '0);
    end
endmodule

// File: rtl/mesh_rtr_inq.sv
module mesh_rtr_inq
    import mesh_rtr_pkg::*;
#(
    parameter int FW    = 16,
    parameter int DEPTH = 4,
    parameter int CW    = 3,
    parameter int X_POS = 2,
    parameter int Y_POS = 2,
    parameter int CLASS = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  logic [FW-1:0]          push_flit,
    input  logic                   grant,
    input  logic [NPORT*NVC-1:0]   ovc_held,
    input  logic [NPORT*NVC-1:0]   ovc_ok,
    output logic                   req,
    output logic [PSEL_W-1:0]      req_port,
    output logic                   req_vc,
    output logic [FW-1:0]          front,
    output logic                   crd_up
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [FW-1:0]     mem [DEPTH];
    logic [AW-1:0]     wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q;
    iv_state_e         state_q, state_d;
    logic [PSEL_W-1:0] lk_port_q;
    logic              lk_vc_q;
    logic [PSEL_W-1:0] xy_p, yx_p, cand_p;
    logic              cand_v;
    logic [IDX_W-1:0]  cand_i, lk_i;
    logic              nonempty, is_head, is_tail;

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_flit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= '0;
            rd_q   <= '0;
            cnt_q  <= '0;
            crd_up <= 1'b0;
        end else begin
            if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (grant) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q  <= cnt_q + CNT_W'(push) - CNT_W'(grant);
            crd_up <= grant;
        end
    end

    always_comb begin
        front    = mem[rd_q];
        nonempty = (cnt_q != '0);
        is_head  = front[FW-1];
        is_tail  = front[FW-2];
        xy_p = route_xy(int'(front[CW-1:0]), int'(front[2*CW-1:CW]), X_POS, Y_POS);
        yx_p = route_yx(int'(front[CW-1:0]), int'(front[2*CW-1:CW]), X_POS, Y_POS);
        cand_p = xy_p;
        cand_v = 1'b0;
        if ((CLASS != 0) || ovc_held[{xy_p, 1'b0}]) begin
            cand_p = yx_p;
            cand_v = 1'b1;
        end
        cand_i = {cand_p, cand_v};
        lk_i   = {lk_port_q, lk_vc_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= IV_IDLE;
            lk_port_q <= P_LOC;
            lk_vc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == IV_IDLE && grant) begin
                lk_port_q <= cand_p;
                lk_vc_q   <= cand_v;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IV_IDLE:   if (grant && !is_tail) state_d = IV_ACTIVE;
            IV_ACTIVE: if (grant && is_tail)  state_d = IV_IDLE;
            default:   state_d = IV_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IV_IDLE: begin
                req      = nonempty && is_head && !ovc_held[cand_i] && ovc_ok[cand_i];
                req_port = cand_p;
                req_vc   = cand_v;
            end
            IV_ACTIVE: begin
                req      = nonempty && ovc_ok[lk_i];
                req_port = lk_port_q;
                req_vc   = lk_vc_q;
            end
            default: begin
                req      = 1'b0;
                req_port = P_LOC;
                req_vc   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mesh_rtr.sv
module mesh_rtr
    import mesh_rtr_pkg::*;
#(
    parameter int FW    = 16,
    parameter int DEPTH = 4,
    parameter int CW    = 3,
    parameter int X_POS = 2,
    parameter int Y_POS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT-1:0]       in_valid,
    input  logic [NPORT-1:0]       in_vc,
    input  logic [NPORT*FW-1:0]    in_flit,
    output logic [NPORT*NVC-1:0]   in_crd,
    output logic [NPORT-1:0]       out_valid,
    output logic [NPORT-1:0]       out_vc,
    output logic [NPORT*FW-1:0]    out_flit,
    input  logic [NPORT*NVC-1:0]   out_crd
);
    localparam int NI = NPORT * NVC;

    logic [NI-1:0]             qgrant, qreq, qvc;
    logic [PSEL_W-1:0]         qport [NI];
    logic [FW-1:0]             qfront [NI];
    logic [NI-1:0]             ovc_held, ovc_ok, ovc_send, ovc_claim, ovc_rel;
    logic [NPORT-1:0][NI-1:0]  preq, gnt;
    logic [FW-1:0]             sel_flit [NPORT];
    logic [NPORT-1:0]          sel_vc;

    for (genvar ip = 0; ip < NPORT; ip++) begin : g_ip
        for (genvar iv = 0; iv < NVC; iv++) begin : g_iv
            mesh_rtr_inq #(
                .FW(FW), .DEPTH(DEPTH), .CW(CW),
                .X_POS(X_POS), .Y_POS(Y_POS), .CLASS(iv)
            ) u_q (
                .clk(clk),
                .rst_n(rst_n),
                .push(in_valid[ip] && (in_vc[ip] == 1'(iv))),
                .push_flit(in_flit[ip*FW +: FW]),
                .grant(qgrant[ip*NVC+iv]),
                .ovc_held(ovc_held),
                .ovc_ok(ovc_ok),
                .req(qreq[ip*NVC+iv]),
                .req_port(qport[ip*NVC+iv]),
                .req_vc(qvc[ip*NVC+iv]),
                .front(qfront[ip*NVC+iv]),
                .crd_up(in_crd[ip*NVC+iv])
            );
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            for (int i = 0; i < NI; i++) begin
                preq[p][i] = qreq[i] && (qport[i] == PSEL_W'(p));
            end
        end
    end

    for (genvar op = 0; op < NPORT; op++) begin : g_arb
        mesh_rtr_rr #(.N(NI)) u_arb (
            .clk(clk),
            .rst_n(rst_n),
            .req(preq[op]),
            .grant(gnt[op])
        );
    end

    for (genvar op = 0; op < NPORT; op++) begin : g_op
        for (genvar ov = 0; ov < NVC; ov++) begin : g_ov
            mesh_rtr_ovc #(.DEPTH(DEPTH)) u_ovc (
                .clk(clk),
                .rst_n(rst_n),
                .send(ovc_send[op*NVC+ov]),
                .claim(ovc_claim[op*NVC+ov]),
                .rel(ovc_rel[op*NVC+ov]),
                .crd_in(out_crd[op*NVC+ov]),
                .held(ovc_held[op*NVC+ov]),
                .ok(ovc_ok[op*NVC+ov])
            );
        end
    end

    always_comb begin
        for (int i = 0; i < NI; i++) begin
            qgrant[i] = 1'b0;
            for (int p = 0; p < NPORT; p++) begin
                qgrant[i] = qgrant[i] | gnt[p][i];
            end
        end
        for (int p = 0; p < NPORT; p++) begin
            for (int v = 0; v < NVC; v++) begin
                ovc_send[p*NVC+v]  = 1'b0;
                ovc_claim[p*NVC+v] = 1'b0;
                ovc_rel[p*NVC+v]   = 1'b0;
                for (int i = 0; i < NI; i++) begin
                    if (gnt[p][i] && (qvc[i] == 1'(v))) begin
                        ovc_send[p*NVC+v]  = 1'b1;
                        ovc_claim[p*NVC+v] = qfront[i][FW-1] && !qfront[i][FW-2];
                        ovc_rel[p*NVC+v]   = qfront[i][FW-2] && !qfront[i][FW-1];
                    end
                end
            end
        end
        for (int p = 0; p < NPORT; p++) begin
            sel_flit[p] = '0;
            sel_vc[p]   = 1'b0;
            for (int i = 0; i < NI; i++) begin
                if (gnt[p][i]) begin
                    sel_flit[p] = qfront[i];
                    sel_vc[p]   = qvc[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_vc    <= '0;
            out_flit  <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                out_valid[p]          <= |gnt[p];
                out_vc[p]             <= sel_vc[p];
                out_flit[p*FW +: FW]  <= sel_flit[p];
            end
        end
    end
endmodule

// File: rtl/mesh_rtr_chk.sv
module mesh_rtr_chk
    import mesh_rtr_pkg::*;
#(
    parameter int FW    = 16,
    parameter int DEPTH = 4,
    parameter int CW    = 3,
    parameter int X_POS = 2,
    parameter int Y_POS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NPORT-1:0]      in_valid,
    input logic [NPORT-1:0]      in_vc,
    input logic [NPORT*NVC-1:0]  in_crd,
    input logic [NPORT-1:0]      out_valid,
    input logic [NPORT-1:0]      out_vc,
    input logic [NPORT*FW-1:0]   out_flit,
    input logic [NPORT*NVC-1:0]  out_crd
);
    localparam int CNT_W = $clog2(DEPTH + 2);

    // R1: quiet outputs straight out of reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0 && in_crd == '0));

    for (genvar p = 0; p < NPORT; p++) begin : g_p
        logic [FW-1:0] f;
        assign f = out_flit[p*FW +: FW];

        // R6: a forwarded flit carries known values
        assert_known_flit_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] |-> !$isunknown(f));

        // R2: primary-class heads leave through the X-first port
        assert_xy_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && !out_vc[p] && f[FW-1]) |->
            (route_xy(int'(f[CW-1:0]), int'(f[2*CW-1:CW]), X_POS, Y_POS) == PSEL_W'(p)));

        // R4, R5: escape-class heads leave through the Y-first port
        assert_yx_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && out_vc[p] && f[FW-1]) |->
            (route_yx(int'(f[CW-1:0]), int'(f[2*CW-1:CW]), X_POS, Y_POS) == PSEL_W'(p)));

        if (p == 0) begin : g_loc
            // R3: only packets addressed to this tile are ejected locally
            assert_local_eject_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid[p] && f[FW-1]) |->
                (int'(f[CW-1:0]) == X_POS && int'(f[2*CW-1:CW]) == Y_POS));
        end

        for (genvar v = 0; v < NVC; v++) begin : g_v
            logic [CNT_W-1:0] dn_q, occ_q;
            logic sent, pushed;
            assign sent   = out_valid[p] && (out_vc[p] == 1'(v));
            assign pushed = in_valid[p] && (in_vc[p] == 1'(v));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dn_q  <= CNT_W'(DEPTH);
                    occ_q <= '0;
                end else begin
                    dn_q  <= dn_q - CNT_W'(sent) + CNT_W'(out_crd[p*NVC+v]);
                    occ_q <= occ_q + CNT_W'(pushed) - CNT_W'(in_crd[p*NVC+v]);
                end
            end

            // R7: never send without a downstream credit
            assert_credit_R7: assert property (@(posedge clk) disable iff (!rst_n)
                sent |-> (dn_q != '0));

            // R8: no upstream push beyond the queue depth
            assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
                pushed |-> (occ_q < CNT_W'(DEPTH)));

            // R8: a credit only returns for a flit that was buffered
            assert_credit_backed_R8: assert property (@(posedge clk) disable iff (!rst_n)
                in_crd[p*NVC+v] |-> (occ_q != '0));
        end
    end
endmodule

bind mesh_rtr mesh_rtr_chk #(
    .FW(FW), .DEPTH(DEPTH), .CW(CW), .X_POS(X_POS), .Y_POS(Y_POS)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .in_valid(in_valid),
    .in_vc(in_vc),
    .in_crd(in_crd),
    .out_valid(out_valid),
    .out_vc(out_vc),
    .out_flit(out_flit),
    .out_crd(out_crd)
);

// File: tb/mesh_rtr_tb.sv
module mesh_rtr_tb;
    localparam int FW = 16, DEPTH = 4, CW = 3, MX = 2, MY = 2;
    localparam int NP = 5, NQ = 10;
    localparam int PL = 0, PN = 1, PS = 2, PE = 3, PW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     in_valid = '0;
    logic [NP-1:0]     in_vc = '0;
    logic [NP*FW-1:0]  in_flit = '0;
    logic [NQ-1:0]     in_crd;
    logic [NP-1:0]     out_valid;
    logic [NP-1:0]     out_vc;
    logic [NP*FW-1:0]  out_flit;
    logic [NQ-1:0]     out_crd = '0;

    mesh_rtr #(.FW(FW), .DEPTH(DEPTH), .CW(CW), .X_POS(MX), .Y_POS(MY)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
        .in_flit(in_flit), .in_crd(in_crd), .out_valid(out_valid),
        .out_vc(out_vc), .out_flit(out_flit), .out_crd(out_crd)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    logic [FW-1:0] sbq [NQ][$];
    int sent [NQ], ret [NQ], rcv [NQ], withheld [NQ], head_cyc [NQ], ret_cyc [NQ];
    bit hold [NQ];
    bit log_on = 1'b0;
    int east_log [$];

    initial begin
        for (int i = 0; i < NQ; i++) begin
            sent[i] = 0; ret[i] = 0; rcv[i] = 0; withheld[i] = 0;
            head_cyc[i] = 0; ret_cyc[i] = 0; hold[i] = 1'b0;
        end
    end

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int ref_xy(int dx, int dy);
        if (dx != MX) return (dx > MX) ? PE : PW;
        if (dy != MY) return (dy > MY) ? PN : PS;
        return PL;
    endfunction

    function automatic int ref_yx(int dx, int dy);
        if (dy != MY) return (dy > MY) ? PN : PS;
        if (dx != MX) return (dx > MX) ? PE : PW;
        return PL;
    endfunction

    // monitor: scoreboard compare, downstream credit model, upstream credit count
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                if (out_valid[p]) begin
                    automatic int o = p * 2 + int'(out_vc[p]);
                    automatic logic [FW-1:0] f = out_flit[p*FW +: FW];
                    rcv[o]++;
                    if (f[FW-1]) head_cyc[o] = cyc;
                    if (p == PE && log_on) east_log.push_back(int'(out_vc[p]));
                    if (sbq[o].size() == 0) begin
                        chk(1'b0, "R6 unexpected flit on port*2+vc", o, -1);
                    end else begin
                        automatic logic [FW-1:0] e = sbq[o].pop_front();
                        chk(f == e, "R6 flit order and lock", int'(f), int'(e));
                    end
                    withheld[o]++;
                end
            end
            for (int i = 0; i < NQ; i++) begin
                if (in_crd[i]) begin
                    ret[i]++;
                    ret_cyc[i] = cyc;
                end
            end
            for (int o = 0; o < NQ; o++) begin
                out_crd[o] = 1'b0;
                if (!hold[o] && withheld[o] > 0) begin
                    out_crd[o] = 1'b1;
                    withheld[o]--;
                end
            end
        end
    end

    task automatic send_flit(int p, int v, logic [FW-1:0] f);
        while (DEPTH - sent[p*2+v] + ret[p*2+v] <= 0) @(negedge clk);
        in_valid[p] = 1'b1;
        in_vc[p] = v[0];
        in_flit[p*FW +: FW] = f;
        sent[p*2+v]++;
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    task automatic send_pkt(int p, int v, int dx, int dy, int n, int tag, int op, int ov);
        for (int k = 0; k < n; k++) begin
            automatic logic [FW-1:0] f;
            f[FW-1] = (k == 0);
            f[FW-2] = (k == n - 1);
            if (k == 0) f[FW-3:0] = 14'((tag << 6) | (dy << 3) | dx);
            else        f[FW-3:0] = 14'((tag << 6) | k);
            sbq[op*2+ov].push_back(f);
            send_flit(p, v, f);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_empty(string tag);
        automatic int tot = 0;
        for (int o = 0; o < NQ; o++) tot += sbq[o].size();
        chk(tot == 0, tag, tot, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
        $finish;
    end

    initial begin
        int t0, base;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(in_crd == '0, "R1 in_crd in reset", int'(in_crd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_crd == '0, "R1 in_crd after reset", int'(in_crd), 0);

        // R2 and R10: X-first routing, two-edge latency
        t0 = cyc;
        send_pkt(PW, 0, 5, 2, 3, 1, ref_xy(5, 2), 0);
        settle(6);
        chk(head_cyc[PE*2] - t0 == 2, "R10 head latency", head_cyc[PE*2] - t0, 2);
        send_pkt(PL, 0, 2, 5, 2, 2, ref_xy(2, 5), 0);
        send_pkt(PE, 0, 0, 2, 2, 3, ref_xy(0, 2), 0);
        send_pkt(PS, 0, 1, 4, 3, 4, ref_xy(1, 4), 0);
        send_pkt(PN, 0, 3, 0, 2, 5, ref_xy(3, 0), 0);
        settle(8);
        expect_empty("R2 X-first packets delivered");
        chk(rcv[PW*2] == 5, "R2 X before Y toward west", rcv[PW*2], 5);

        // R3 and R8: single-flit ejection and credit timing
        t0 = cyc;
        send_pkt(PN, 0, 2, 2, 1, 6, PL, 0);
        settle(6);
        chk(rcv[PL*2] == 1, "R3 local ejection", rcv[PL*2], 1);
        chk(ret_cyc[PN*2] == head_cyc[PL*2], "R8 credit in exit cycle",
            ret_cyc[PN*2], head_cyc[PL*2]);

        // R5: escape class keeps Y-first order
        send_pkt(PS, 1, 4, 4, 2, 7, ref_yx(4, 4), 1);
        send_pkt(PS, 1, 0, 2, 2, 8, ref_yx(0, 2), 1);
        send_pkt(PS, 1, 4, 0, 2, 9, ref_yx(4, 0), 1);
        settle(8);
        expect_empty("R5 Y-first packets delivered");
        chk(rcv[PN*2+1] == 2, "R5 vertical first on escape", rcv[PN*2+1], 2);

        // R7: credits stop a held packet after DEPTH flits
        hold[PE*2] = 1'b1;
        base = rcv[PE*2];
        send_pkt(PW, 0, 6, 2, 6, 10, PE, 0);
        settle(10);
        chk(rcv[PE*2] - base == DEPTH, "R7 stop at zero credit", rcv[PE*2] - base, DEPTH);

        // R4: primary channel held, heads divert onto the escape class
        send_pkt(PL, 0, 4, 4, 2, 11, PN, 1);
        send_pkt(PL, 0, 5, 2, 2, 12, PE, 1);
        settle(8);
        chk(sbq[PN*2+1].size() == 0, "R4 divert to north escape", sbq[PN*2+1].size(), 0);
        chk(sbq[PE*2+1].size() == 0, "R4 east link shared by escape", sbq[PE*2+1].size(), 0);
        chk(rcv[PE*2] - base == DEPTH, "R7 still stalled", rcv[PE*2] - base, DEPTH);

        hold[PE*2] = 1'b0;
        settle(10);
        chk(rcv[PE*2] - base == 6, "R7 resume on credit return", rcv[PE*2] - base, 6);
        expect_empty("R7 held packet completed");

        // R6: channel released after tail, no diversion
        base = rcv[PE*2];
        send_pkt(PL, 0, 5, 3, 2, 13, PE, 0);
        settle(6);
        chk(rcv[PE*2] - base == 2, "R6 released channel reused", rcv[PE*2] - base, 2);
        expect_empty("R6 all delivered");

        // R9: two channels competing for the east link
        log_on = 1'b1;
        fork
            send_pkt(PW, 0, 5, 2, 5, 14, PE, 0);
            send_pkt(PS, 1, 5, 2, 5, 15, PE, 1);
        join
        settle(16);
        log_on = 1'b0;
        chk(east_log.size() == 10, "R9 east flits logged", east_log.size(), 10);
        begin
            automatic int same = 0;
            for (int k = 1; k < 8 && k < east_log.size(); k++)
                if (east_log[k] == east_log[k-1]) same++;
            chk(same == 0, "R9 round-robin alternation", same, 0);
        end
        expect_empty("R9 all delivered");

        // R8: one credit per forwarded flit
        for (int i = 0; i < NQ; i++)
            chk(sent[i] == ret[i], "R8 credits match flits", ret[i], sent[i]);

        summary();
        $finish;
    end
endmodule